// File: doc/BRIEF.md
# IR Run-Length Receive Sampler

The block watches a demodulated infrared input and turns it into a stream of run-length bytes. A free-running tick, programmable in whole microseconds, samples the synchronized input. The block counts how many ticks the input stays at one level. Each time the level changes, the finished run is written as one byte into an eight-byte buffer. The byte holds the count and a flag that marks the run as a pulse or a gap.

The buffer works as two halves of four bytes each, used in ping-pong fashion. When the hardware completes a half, that half is handed to the host and a pending flag is raised; the rx interrupt enable can route this flag to the interrupt output. The host reads the four bytes of the half named by the read-half flag. It then writes 1 to the pending bit, which releases that half and moves the read-half flag to the other half.

A run longer than the 7-bit count can hold is split into several bytes. Each split can raise an optional overflow interrupt. Samples that arrive while both halves are still held by the host are discarded, and a sticky lost bit is set.

Top module: `ir_rle_sampler`

## Requirements
- R1: After reset the control register (address 0x8) reads 0x00, the period register (address 0x9) reads 0x32 (50 µs, overflow interrupt off), the status register (address 0xA) reads 0x00, and `irq` is low.
- R2: Each sample byte has bit 7 = 1 for a gap and bit 7 = 0 for a pulse, with the run length in ticks in bits 6:0. With inversion off, `ir_in` = 1 is a pulse. Runs are stored in the order they end, at buffer addresses 0x0 to 0x7 in turn, and the write position wraps after 0x7. A run is stored on the first tick that sees the new level. A zero-length run (the gap counter after enable, when the input is already pulsing) is not stored.
- R3: `ir_in` passes through a two-flop synchronizer. Samples are taken every CLK_PER_US × P clock cycles, where P is period register bits 6:0 and a value of 0 acts as 1. The first tick falls that many cycles after enable (control bit 0) is set.
- R4: Control bit 1 inverts the input before sampling, so `ir_in` = 0 is then a pulse.
- R5: When the fourth byte of a half is stored, that half becomes full. Status bit 1 (pending) is high while the half named by status bit 0 (0: bytes 0x0-0x3, 1: bytes 0x4-0x7) is full. Writing status with bit 1 set while pending releases that half and toggles status bit 0. `irq` is high while pending and control bit 2 (rx interrupt enable) are both set.
- R6: A run reaching 127 ticks stores a byte with count 127 on that tick, and counting restarts from zero at the same level. A run of exactly 127 ticks therefore yields one byte.
- R7: Status bit 3 (overflow) is set on a saturating tick only when period register bit 7 is set. It is cleared by writing status with bit 3 set. It drives `irq` regardless of control bit 2.
- R8: A sample that falls on a half that is still full is discarded and sets status bit 2 (lost), which stays set until status is written with bit 2 set. The write position does not move.
- R9: While control bit 0 is clear, no sample is stored. The write position, both half-full marks and status bit 0 are cleared, so pending reads 0.
- R10: Writing status bit 1 while nothing is pending has no effect on status bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_in | input | 1 | Demodulated IR level, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0x0-0x7 buffer, 0x8 control, 0x9 period, 0xA status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| irq | output | 1 | Interrupt: pending gated by rx enable, or overflow |

## Verification
The hardware can complete one half on the same clock edge on which the host writes the acknowledge that releases the other half. Each update must land on its own half-full mark without disturbing the other. Random streams of runs as short as one tick run against a polling host, so completions and acknowledges overlap on many edges. Every byte read is compared with the runs the bench scheduled, together with the expected read-half flag.

// File: rtl/ir_rle_sampler.sv
module ir_rle_sampler #(
  parameter int CLK_PER_US = 50,
  parameter int PRE_W      = $clog2(CLK_PER_US + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_in,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [1:0] sync;
  logic [7:0] ctl, per;
  logic [PRE_W-1:0] pre;
  logic [6:0] us;
  logic       cur;
  logic [6:0] cnt;
  logic [7:0] mem [8];
  logic [2:0] wp;
  logic [1:0] full;
  logic       rdh, lost, ovf;

  wire       en      = ctl[0];
  wire       inv     = ctl[1];
  wire       rxie    = ctl[2];
  wire [6:0] per_eff = (per[6:0] == 7'd0) ? 7'd1 : per[6:0];
  wire       tick    = en && (pre == PRE_LAST) && (us == per_eff - 7'd1);
  wire       lvl     = sync[1] ^ inv;
  wire       chg     = lvl != cur;
  wire       sat     = !chg && (cnt == 7'd126);
  wire       emit    = tick && ((chg && cnt != 7'd0) || sat);
  wire [7:0] smp     = {~cur, sat ? 7'd127 : cnt};
  wire       wh      = wp[2];
  wire       drop    = emit && full[wh];
  wire       put     = emit && !full[wh];
  wire       done    = put && (wp[1:0] == 2'b11);
  wire       pend    = full[rdh];
  wire       st_wr   = reg_we && (reg_addr == 4'hA);
  wire       ack     = st_wr && reg_wdata[1] && pend;

  assign irq = (rxie && pend) || ovf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b00;
    else        sync <= {sync[0], ir_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl <= 8'h00;
      per <= 8'd50;
    end else if (reg_we) begin
      if (reg_addr == 4'h8) ctl <= {5'b0, reg_wdata[2:0]};
      if (reg_addr == 4'h9) per <= reg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0;
      us  <= 7'd0;
    end else if (!en) begin
      pre <= '0;
      us  <= 7'd0;
    end else if (pre == PRE_LAST) begin
      pre <= '0;
      us  <= (us == per_eff - 7'd1) ? 7'd0 : us + 7'd1;
    end else begin
      pre <= pre + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur <= 1'b0;
      cnt <= 7'd0;
    end else if (!en) begin
      cur <= 1'b0;
      cnt <= 7'd0;
    end else if (tick) begin
      if (chg) begin
        cur <= lvl;
        cnt <= 7'd1;
      end else if (sat) begin
        cnt <= 7'd0;
      end else begin
        cnt <= cnt + 7'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= 8'h00;
    end else if (put) begin
      mem[wp] <= smp;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp   <= 3'd0;
      full <= 2'b00;
      rdh  <= 1'b0;
    end else if (!en) begin
      wp   <= 3'd0;
      full <= 2'b00;
      rdh  <= 1'b0;
    end else begin
      if (put)  wp <= wp + 3'd1;
      if (ack) begin
        full[rdh] <= 1'b0;
        rdh       <= ~rdh;
      end
      if (done) full[wh] <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     lost <= 1'b0;
    else if (drop)                  lost <= 1'b1;
    else if (st_wr && reg_wdata[2]) lost <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     ovf <= 1'b0;
    else if (tick && sat && per[7]) ovf <= 1'b1;
    else if (st_wr && reg_wdata[3]) ovf <= 1'b0;

  always_comb begin
    reg_rdata = 8'h00;
    if (!reg_addr[3]) reg_rdata = mem[reg_addr[2:0]];
    else if (reg_addr == 4'h8) reg_rdata = ctl;
    else if (reg_addr == 4'h9) reg_rdata = per;
    else if (reg_addr == 4'hA) reg_rdata = {4'b0, ovf, lost, pend, rdh};
  end
endmodule

// File: rtl/ir_rle_sampler_chk.sv
module ir_rle_sampler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       st_wr,
  input logic [7:0] wdata,
  input logic       pend,
  input logic       rdh,
  input logic       lost,
  input logic       ovf,
  input logic       per7,
  input logic [2:0] wp,
  input logic [1:0] full
);
  a_r5_ack_flips_half: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_wr && wdata[1] && pend) |=> (rdh != $past(rdh)));

  a_r10_idle_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_wr && wdata[1] && !pend) |=> $stable(rdh));

  a_r8_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !(st_wr && wdata[2])) |=> lost);

  a_r8_full_holds_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (en && full[wp[2]]) |=> ($stable(wp) || wp == 3'd0));

  a_r7_ovf_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(per7));

  a_r9_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (wp == 3'd0 && full == 2'b00 && !rdh));
endmodule

bind ir_rle_sampler ir_rle_sampler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .st_wr(st_wr), .wdata(reg_wdata),
  .pend(pend), .rdh(rdh), .lost(lost), .ovf(ovf), .per7(per[7]),
  .wp(wp), .full(full)
);

// File: tb/ir_rle_sampler_tb.sv
module ir_rle_sampler_tb;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_in = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  int segs[$];
  logic [7:0] expq[$];
  logic inv_b = 1'b0;
  int tper = CPU;

  always #10 clk = ~clk;

  ir_rle_sampler #(.CLK_PER_US(CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic build_exp();
    expq.delete();
    foreach (segs[i]) begin
      int d = segs[i];
      logic sp = (i % 2 == 0);
      while (d >= 127) begin
        expq.push_back({sp, 7'd127});
        d -= 127;
      end
      if (d > 0) expq.push_back({sp, 7'(d)});
    end
  endtask

  // Drives the segments; assumes the enable write edge has just passed.
  task automatic drive();
    logic pl = 1'b0;
    foreach (segs[i]) begin
      int w = (i == 0) ? segs[i] * tper - 2 : segs[i] * tper;
      repeat (w) @(posedge clk);
      @(negedge clk);
      pl = ~pl;
      ir_in = pl ^ inv_b;
    end
  endtask

  task automatic start(input logic [7:0] per, input logic inv, input logic rxie);
    wr(4'h8, 8'h00);
    wr(4'hA, 8'h0E);
    wr(4'h9, per);
    inv_b = inv;
    tper = CPU * ((per[6:0] == 0) ? 1 : int'(per[6:0]));
    @(negedge clk); ir_in = inv;
    repeat (4) @(posedge clk);
    wr(4'h8, {5'b0, rxie, inv, 1'b1});
  endtask

  task automatic consume(input logic rxie);
    int got = 0;
    int guard = 0;
    logic eh = 1'b0;
    logic [7:0] s, b;
    while (got < expq.size() && guard < 20000) begin
      rd(4'hA, s);
      if (s[1]) begin
        chk("R5 read-half flag", {7'b0, s[0]}, {7'b0, eh});
        if (rxie) chk("R5 irq on pending", {7'b0, irq}, 8'h01);
        for (int k = 0; k < 4; k++) begin
          rd(4'({eh, 2'(k)}), b);
          chk("R2 R3 R4 sample byte", b, expq[got + k]);
        end
        wr(4'hA, 8'h02);
        got += 4;
        eh = ~eh;
      end else begin
        guard++;
      end
    end
    if (got < expq.size()) chk("R5 halves delivered", 8'(got), 8'(expq.size()));
    rd(4'hA, s);
    chk("R5 nothing pending after last ack", {6'b0, s[1], s[0]}, {6'b0, 1'b0, eh});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, b0;
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4'h8, v); chk("R1 control reset", v, 8'h00);
    rd(4'h9, v); chk("R1 period reset", v, 8'h32);
    rd(4'hA, v); chk("R1 status reset", v, 8'h00);
    chk("R1 irq reset", {7'b0, irq}, 8'h00);

    // Random streams against a polling host (R2 R3 R4 R5)
    for (int t = 0; t < 20; t++) begin
      logic [7:0] per;
      logic inv, rxie;
      int nseg;
      per  = 8'($urandom_range(0, 2));
      inv  = 1'($urandom_range(0, 1));
      rxie = 1'($urandom_range(0, 1));
      nseg = 4 * $urandom_range(2, 3);
      segs.delete();
      for (int i = 0; i < nseg; i++)
        segs.push_back((t < 3) ? 1 : $urandom_range(1, 24));
      build_exp();
      start(per, inv, rxie);
      fork
        drive();
        consume(rxie);
      join
      wr(4'h8, 8'h00);
    end

    // R9: disabled block stores nothing and clears half state
    rd(4'h0, b0);
    for (int i = 0; i < 6; i++) begin
      repeat (20) @(posedge clk);
      @(negedge clk); ir_in = ~ir_in;
    end
    rd(4'h0, v); chk("R9 buffer untouched while disabled", v, b0);
    rd(4'hA, v); chk("R9 half state cleared", v & 8'h03, 8'h00);

    // R8 / R10: host stalls, ninth sample is dropped
    segs.delete();
    for (int i = 0; i < 10; i++) segs.push_back($urandom_range(2, 6));
    build_exp();
    start(8'h01, 1'b0, 1'b1);
    drive();
    repeat (2 * tper) @(posedge clk);
    rd(4'hA, v); chk("R8 lost set, half 0 pending", v, 8'h06);
    chk("R5 irq while pending", {7'b0, irq}, 8'h01);
    for (int k = 0; k < 4; k++) begin
      rd(4'(k), v); chk("R8 first half kept", v, expq[k]);
    end
    wr(4'hA, 8'h02);
    rd(4'hA, v); chk("R5 ack moves to half 1", v, 8'h07);
    for (int k = 0; k < 4; k++) begin
      rd(4'(4 + k), v); chk("R8 second half kept", v, expq[4 + k]);
    end
    wr(4'hA, 8'h02);
    rd(4'hA, v); chk("R5 both halves released", v, 8'h04);
    wr(4'hA, 8'h02);
    rd(4'hA, v); chk("R10 idle ack ignored", v, 8'h04);
    wr(4'hA, 8'h04);
    rd(4'hA, v); chk("R8 lost cleared", v, 8'h00);

    // R6 / R7: saturation with overflow interrupt enabled
    segs = '{3, 130, 2};
    build_exp();
    start(8'h81, 1'b0, 1'b0);
    drive();
    repeat (2 * tper) @(posedge clk);
    rd(4'hA, v); chk("R7 overflow and pending", v, 8'h0A);
    chk("R7 irq from overflow", {7'b0, irq}, 8'h01);
    rd(4'h0, v); chk("R6 leading gap", v, 8'h83);
    rd(4'h1, v); chk("R6 saturated pulse", v, 8'h7F);
    rd(4'h2, v); chk("R6 pulse remainder", v, 8'h03);
    rd(4'h3, v); chk("R6 trailing gap", v, 8'h82);
    wr(4'hA, 8'h08);
    rd(4'hA, v); chk("R7 overflow cleared", v, 8'h02);
    chk("R7 irq low with rx irq off", {7'b0, irq}, 8'h00);
    wr(4'hA, 8'h02);

    // R6 exact 127 run, R7 overflow disabled
    segs = '{2, 127, 1, 4};
    build_exp();
    start(8'h01, 1'b0, 1'b0);
    drive();
    repeat (2 * tper) @(posedge clk);
    rd(4'hA, v); chk("R7 no overflow when disabled", v, 8'h02);
    rd(4'h1, v); chk("R6 exact 127 single byte", v, 8'h7F);
    rd(4'h2, v); chk("R6 next run after 127", v, 8'h81);
    rd(4'h3, v); chk("R6 fourth byte", v, 8'h04);
    wr(4'h8, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule